// File: doc/BRIEF.md
# Zero-Cross Gated Volume Updater

This block keeps an 8-bit input volume code and moves the active gain to a new code only at a safe moment. A safe moment is a sample that carries a zero-cross flag, or the end of a timeout measured in sample strobes. Applying the change at one of these points prevents audible steps in the gain. A register write arms an update. Each accepted write restarts the timeout count. A write that repeats the stored code is dropped and does not restart the count.

While the automatic level control (ALC) enable is high, the volume register is frozen and ALC's own gain code takes over the gain output. The hand-over to ALC also waits for a zero crossing or a timeout. When ALC is switched off, the gain returns to the last code that was accepted into the register, again at a zero crossing or a timeout.

The gain scale is 0.375 dB per code step, so code E1h gives +30 dB and code F1h gives +36 dB.

Top module: `zc_vol_updater`

## Requirements
- R1: After reset, gain_o is E1h and no update is pending. A zero-cross sample that follows reset leaves gain_o at E1h.
- R2: A write accepted while ALC is off sets gain_o to the written code on the first later sample strobe that has zc_i high. Until that sample, gain_o keeps its old value.
- R3: With no zero crossing, a pending code is applied on the Nth sample strobe after the write that restarted the count. N is 16, 32, 64 or 128 for tmo_sel_i values 0, 1, 2 and 3.
- R4: Every accepted write restarts the timeout count. If writes with changing codes arrive less than N samples apart and no zero crossing occurs, gain_o does not change.
- R5: A write whose data equals the stored register code is discarded. It does not restart the timeout count.
- R6: A zero-cross sample with no pending update does not change gain_o. A pending update is cleared once it is applied.
- R7: While alc_en_i is high, writes do not change the volume register. This is seen at the ports through the code that gain_o returns to after ALC is switched off.
- R8: After alc_en_i rises, gain_o takes alc_gain_i on the first sample with zc_i high, or on the Nth sample strobe. From then on, gain_o follows alc_gain_i one cycle later for as long as alc_en_i stays high.
- R9: After alc_en_i falls, gain_o returns to the stored register code at the next zero-cross sample, or on the Nth sample strobe.
- R10: An accepted write in the same cycle as a zero-cross sample is not applied in that cycle. It restarts the count, and the update waits for a later zero crossing or timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Volume register write strobe |
| wr_data_i | input | 8 | Volume code to write |
| sample_i | input | 1 | One-cycle strobe per audio sample |
| zc_i | input | 1 | Zero crossing on this sample; valid only with sample_i |
| tmo_sel_i | input | 2 | Timeout length select |
| alc_en_i | input | 1 | ALC enable |
| alc_gain_i | input | 8 | Gain code produced by ALC |
| gain_o | output | 8 | Active gain code |

## Verification
The case that is hardest to reach from the ports is a timeout expiring after a chain of restarts. Reaching it needs a long run of samples with no zero crossing, interrupted by writes whose codes differ from the stored one at gaps shorter than the timeout. Directed sequences spell out these gaps with exact sample counts, including a repeated code that must not restart the count, and check the exact sample on which the gain moves. Random traffic with rare zero-cross flags and occasional ALC toggles then lets timeouts occur from every mode, and a cycle-level reference model written from the requirements checks the gain on every cycle.

// File: rtl/zcv_pkg.sv
package zcv_pkg;
  typedef enum logic [1:0] {
    MODE_MAN  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_RUN  = 2'd2
  } zcv_mode_e;
endpackage

// File: rtl/zcv_write_filter.sv
module zcv_write_filter #(
  parameter int          GAIN_W   = 8,
  parameter logic [7:0]  DEF_GAIN = 8'hE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [GAIN_W-1:0] wr_data_i,
  input  logic              block_i,
  output logic [GAIN_W-1:0] vol_o,
  output logic              accept_o
);
  logic [GAIN_W-1:0] vol_q;

  // repeated code and writes during ALC are both dropped
  assign accept_o = wr_en_i && !block_i && (wr_data_i != vol_q);
  assign vol_o    = vol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       vol_q <= GAIN_W'(DEF_GAIN);
    else if (accept_o) vol_q <= wr_data_i;
  end
endmodule

// File: rtl/zcv_timeout_cnt.sv
module zcv_timeout_cnt #(
  parameter int TMO_BASE = 16,
  parameter int SEL_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             sample_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             expire_o
);
  localparam int NUM_TMO = 1 << SEL_W;
  localparam int MAX_LIM = TMO_BASE << (NUM_TMO - 1);
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  logic [CNT_W-1:0] lim_tab [NUM_TMO];
  logic [CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < NUM_TMO; g++) begin : g_lim
    assign lim_tab[g] = CNT_W'((TMO_BASE << g) - 1);
  end

  // >= keeps a shortened select from being stranded above its limit
  assign expire_o = sample_i && (cnt_q >= lim_tab[sel_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (sample_i)  cnt_q <= expire_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/zcv_gain_ctrl.sv
module zcv_gain_ctrl
  import zcv_pkg::*;
#(
  parameter int          GAIN_W   = 8,
  parameter logic [7:0]  DEF_GAIN = 8'hE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alc_en_i,
  input  logic              accept_i,
  input  logic              fire_i,
  input  logic [GAIN_W-1:0] vol_i,
  input  logic [GAIN_W-1:0] alc_gain_i,
  output logic              restart_o,
  output logic              pend_o,
  output zcv_mode_e         mode_o,
  output logic [GAIN_W-1:0] gain_o
);
  zcv_mode_e         mode_q, mode_d;
  logic              pend_q, pend_d;
  logic [GAIN_W-1:0] gain_q, gain_d;
  logic              alc_edge;

  assign alc_edge  = (mode_q == MODE_MAN) ? alc_en_i : !alc_en_i;
  assign restart_o = accept_i || alc_edge;

  always_comb begin
    mode_d = mode_q;
    pend_d = pend_q;
    gain_d = gain_q;
    unique case (mode_q)
      MODE_MAN: begin
        if (alc_en_i) begin
          mode_d = MODE_WAIT;
          pend_d = 1'b0;
        end else if (accept_i) begin
          pend_d = 1'b1;
        end else if (pend_q && fire_i) begin
          gain_d = vol_i;
          pend_d = 1'b0;
        end
      end
      MODE_WAIT: begin
        if (!alc_en_i) begin
          mode_d = MODE_MAN;
          pend_d = 1'b1;
        end else if (fire_i) begin
          mode_d = MODE_RUN;
          gain_d = alc_gain_i;
        end
      end
      MODE_RUN: begin
        if (!alc_en_i) begin
          mode_d = MODE_MAN;
          pend_d = 1'b1;
        end else begin
          gain_d = alc_gain_i;
        end
      end
      default: mode_d = MODE_MAN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_MAN;
      pend_q <= 1'b0;
      gain_q <= GAIN_W'(DEF_GAIN);
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
      gain_q <= gain_d;
    end
  end

  assign pend_o = pend_q;
  assign mode_o = mode_q;
  assign gain_o = gain_q;
endmodule

// File: rtl/zc_vol_updater.sv
module zc_vol_updater
  import zcv_pkg::*;
#(
  parameter int          GAIN_W   = 8,
  parameter int          SEL_W    = 2,
  parameter int          TMO_BASE = 16,
  parameter logic [7:0]  DEF_GAIN = 8'hE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [GAIN_W-1:0] wr_data_i,
  input  logic              sample_i,
  input  logic              zc_i,
  input  logic [SEL_W-1:0]  tmo_sel_i,
  input  logic              alc_en_i,
  input  logic [GAIN_W-1:0] alc_gain_i,
  output logic [GAIN_W-1:0] gain_o
);
  logic [GAIN_W-1:0] vol_q;
  logic              accept, restart, expire, fire, pend_q;
  zcv_mode_e         mode_q;

  zcv_write_filter #(.GAIN_W(GAIN_W), .DEF_GAIN(DEF_GAIN)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .block_i  (alc_en_i),
    .vol_o    (vol_q),
    .accept_o (accept)
  );

  zcv_timeout_cnt #(.TMO_BASE(TMO_BASE), .SEL_W(SEL_W)) u_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .sample_i (sample_i),
    .sel_i    (tmo_sel_i),
    .expire_o (expire)
  );

  assign fire = sample_i && (zc_i || expire);

  zcv_gain_ctrl #(.GAIN_W(GAIN_W), .DEF_GAIN(DEF_GAIN)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .alc_en_i  (alc_en_i),
    .accept_i  (accept),
    .fire_i    (fire),
    .vol_i     (vol_q),
    .alc_gain_i(alc_gain_i),
    .restart_o (restart),
    .pend_o    (pend_q),
    .mode_o    (mode_q),
    .gain_o    (gain_o)
  );
endmodule

// File: rtl/zcv_checker.sv
module zcv_checker
  import zcv_pkg::*;
#(
  parameter int GAIN_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [GAIN_W-1:0] wr_data_i,
  input logic              sample_i,
  input logic              zc_i,
  input logic              alc_en_i,
  input logic [GAIN_W-1:0] alc_gain_i,
  input logic [GAIN_W-1:0] gain_o,
  input logic [GAIN_W-1:0] vol_q,
  input logic              accept,
  input logic              pend_q,
  input zcv_mode_e         mode_q
);
  AST_WR_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> pend_q); // R2
  AST_DUP_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i == vol_q) |=> $stable(vol_q)); // R5
  AST_ALC_WR_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alc_en_i |=> $stable(vol_q)); // R7
  AST_ZC_APPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_MAN && pend_q && sample_i && zc_i && !accept && !alc_en_i)
      |=> (gain_o == $past(vol_q) && !pend_q)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_MAN && !pend_q && !alc_en_i) |=> $stable(gain_o)); // R6
  AST_RUN_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RUN && alc_en_i) |=> gain_o == $past(alc_gain_i)); // R8
  AST_ALC_OFF_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_MAN && !alc_en_i) |=> (pend_q && mode_q == MODE_MAN)); // R9
  AST_SAME_CYC_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && sample_i && zc_i) |=> $stable(gain_o)); // R10
endmodule

bind zc_vol_updater zcv_checker #(.GAIN_W(GAIN_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .sample_i  (sample_i),
  .zc_i      (zc_i),
  .alc_en_i  (alc_en_i),
  .alc_gain_i(alc_gain_i),
  .gain_o    (gain_o),
  .vol_q     (vol_q),
  .accept    (accept),
  .pend_q    (pend_q),
  .mode_q    (mode_q)
);

// File: tb/zc_vol_updater_tb.sv
module zc_vol_updater_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       sample_i = 1'b0;
  logic       zc_i = 1'b0;
  logic [1:0] tmo_sel_i = '0;
  logic       alc_en_i = 1'b0;
  logic [7:0] alc_gain_i = '0;
  logic [7:0] gain_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_vol = 8'hE1, m_gain = 8'hE1;
  bit         m_pend = 0;
  int         m_cnt = 0;
  int         m_mode = 0; // 0 manual, 1 waiting for ALC, 2 ALC running

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  zc_vol_updater u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .sample_i(sample_i), .zc_i(zc_i), .tmo_sel_i(tmo_sel_i),
    .alc_en_i(alc_en_i), .alc_gain_i(alc_gain_i), .gain_o(gain_o)
  );

  function automatic int lim(input logic [1:0] s);
    return 16 << s;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: gain actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // advance model by one clock using current inputs, then compare with model
  task automatic tick(input string req);
    bit acc, expire, fire, rst_cnt;
    acc     = wr_en_i && !alc_en_i && (wr_data_i != m_vol);
    expire  = sample_i && (m_cnt >= lim(tmo_sel_i) - 1);
    fire    = sample_i && (zc_i || expire);
    rst_cnt = acc || (m_mode == 0 ? alc_en_i : !alc_en_i);
    if (m_mode == 0) begin
      if (alc_en_i) begin m_mode = 1; m_pend = 0; end
      else if (acc) m_pend = 1;
      else if (m_pend && fire) begin m_gain = m_vol; m_pend = 0; end
    end else if (!alc_en_i) begin
      m_mode = 0; m_pend = 1;
    end else if (m_mode == 2 || fire) begin
      m_mode = 2; m_gain = alc_gain_i;
    end
    if (acc) m_vol = wr_data_i;
    if (rst_cnt) m_cnt = 0;
    else if (sample_i) m_cnt = expire ? 0 : m_cnt + 1;
    @(posedge clk_i);
    #1;
    check(req, gain_o, m_gain);
    @(negedge clk_i);
    wr_en_i = 0; sample_i = 0; zc_i = 0;
  endtask

  task automatic wr(input logic [7:0] d, input string req);
    wr_en_i = 1; wr_data_i = d; tick(req);
  endtask

  task automatic samples(input int n, input string req);
    for (int i = 0; i < n; i++) begin sample_i = 1; tick(req); end
  endtask

  task automatic zc_sample(input string req);
    sample_i = 1; zc_i = 1; tick(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    check("R1 reset value", gain_o, 8'hE1);
    zc_sample("R1 zc after reset");
    check("R1 no pending after reset", gain_o, 8'hE1);

    wr(8'hF1, "R2 write");
    samples(3, "R2 no zc");
    check("R2 held before zc", gain_o, 8'hE1);
    zc_sample("R2 apply");
    check("R2 applied at zc", gain_o, 8'hF1);
    zc_sample("R6 idle zc");
    check("R6 no change on idle zc", gain_o, 8'hF1);

    tmo_sel_i = 2'd1;
    wr(8'hC0, "R3 write");
    samples(31, "R3 count");
    check("R3 before 32nd sample", gain_o, 8'hF1);
    samples(1, "R3 expire");
    check("R3 applied at 32nd sample", gain_o, 8'hC0);

    tmo_sel_i = 2'd0;
    wr(8'hA0, "R4 w1"); samples(10, "R4");
    wr(8'hA1, "R4 w2"); samples(10, "R4");
    wr(8'hA0, "R4 w3"); samples(10, "R4");
    check("R4 restarts hold gain", gain_o, 8'hC0);
    samples(5, "R4");
    check("R4 15 samples after last write", gain_o, 8'hC0);
    samples(1, "R4");
    check("R4 applied at 16th sample", gain_o, 8'hA0);

    wr(8'h90, "R5 first"); samples(10, "R5");
    wr(8'h90, "R5 repeat"); samples(5, "R5");
    check("R5 before timeout", gain_o, 8'hA0);
    samples(1, "R5");
    check("R5 repeat did not restart", gain_o, 8'h90);

    wr_en_i = 1; wr_data_i = 8'h80; sample_i = 1; zc_i = 1; tick("R10 same cycle");
    check("R10 not applied same cycle", gain_o, 8'h90);
    zc_sample("R10 later zc");
    check("R10 applied at next zc", gain_o, 8'h80);

    alc_en_i = 1; alc_gain_i = 8'h55;
    samples(1, "R8 wait");
    check("R8 waits for zc", gain_o, 8'h80);
    wr(8'h33, "R7 blocked write");
    zc_sample("R8 zc");
    check("R8 takes alc gain", gain_o, 8'h55);
    alc_gain_i = 8'h56; tick("R8 follow");
    check("R8 follows alc gain", gain_o, 8'h56);
    alc_en_i = 0; tick("R9 off");
    check("R9 holds until zc", gain_o, 8'h56);
    zc_sample("R9 zc");
    check("R7 R9 restored register code", gain_o, 8'h80);

    alc_en_i = 1; alc_gain_i = 8'h44; tick("R8 enable");
    samples(15, "R8 timeout");
    check("R8 before timeout", gain_o, 8'h80);
    samples(1, "R8 timeout");
    check("R8 timeout to alc", gain_o, 8'h44);
    alc_en_i = 0; tick("R9 off");
    samples(16, "R9 timeout");
    check("R9 timeout restore", gain_o, 8'h80);

    for (int i = 0; i < 4000; i++) begin
      wr_en_i    = ($urandom_range(7) == 0);
      wr_data_i  = ($urandom_range(3) == 0) ? m_vol : 8'($urandom_range(255));
      sample_i   = $urandom_range(1);
      zc_i       = sample_i && ($urandom_range(40) == 0);
      if ($urandom_range(150) == 0) alc_en_i = ~alc_en_i;
      if ($urandom_range(300) == 0) tmo_sel_i = 2'($urandom_range(3));
      if ($urandom_range(20) == 0) alc_gain_i = 8'($urandom_range(255));
      tick("RAND model");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule